// File: doc/BRIEF.md
# Biphase-Mark Digital Audio Transmitter with Channel Status

This block turns a stream of 24-bit stereo samples into a consumer digital audio serial line. Every frame carries one left and one right sub-frame. Each sub-frame has 32 time slots, and each slot is two half-cells. The block runs from a clock at 128 times the sample rate, so one clock cycle is one half-cell. It samples the left and right inputs once per frame, in the cycle flagged by `load_o`.

The channel-status bit in slot 30 comes from a 192-frame block. Part of that block is filled from the configuration inputs: category, rate code, word-length code, pre-emphasis and clock accuracy. The rest is filled by hardware: the channel number, a zero source number, and zeros elsewhere. Before transmission, samples are cut to the programmed word length, or forced to zero while mute is set. A two-bit selector decides what the output pin carries: a constant low, the coded stream, or a second serial data line passed through. A synchronous restart input returns the transmitter to the start of a block.

Top module: `spdif_cs_tx`

## Requirements
- R1: While `rst_n` is low the coded level is 0 and `load_o` is high. After release, the first sub-frame sent is channel A of block frame 0.
- R2: Every sub-frame opens with an 8-half-cell preamble. Channel A of frame 0 uses 11101000, other channel A sub-frames use 11100010, and channel B uses 11100100 (first half-cell leftmost). The pattern is inverted when the level just before it is 1. A block spans 192 frames, so frame 0 recurs every 192 frames.
- R3: Slots 4 to 27 carry the audio sample, least significant bit in slot 4. Slot 28 (validity) and slot 29 (user) are always 0.
- R4: Slots 4 to 31 are biphase-mark coded. The level toggles at the start of every slot and toggles again mid-slot only for a 1.
- R5: Word-length code 00 keeps 16 bits, 01 keeps 20 bits, and 10 or 11 keeps 24 bits. The dropped low-order sample bits are sent as 0.
- R6: While `mute_i` is high at the capture cycle, all 24 audio slots of that frame are 0.
- R7: Slot 31 makes the number of ones in slots 4 to 31 even.
- R8: In channel status, block bits 16-19 are 0 and bits 20-23 hold the value 1 for channel A and 2 for channel B (bit 20 is the value's LSB). Status bit n is sent in frame n of the block.
- R9: Status bits 24-27 (bit 24 is the LSB) hold rate code 00 → 0x0 (44.1 kHz), 01 → 0x2 (48 kHz), 10 → 0x3 (32 kHz) and 11 → 0x1 (not indicated).
- R10: Status bit 3 is the emphasis input, bits 8-15 are the category byte (bit 8 is the LSB), and bits 28-29 are the clock-accuracy field. Bits 32-35 (bit 32 is the LSB) are 0x2 for 16-bit, 0xA for 20-bit and 0xB for 24-bit words. All other status bits are 0.
- R11: `out_sel_i` 00 drives `pin_o` low, 01 drives the coded stream, and 10 or 11 passes `sdout2_i` through in the same cycle.
- R12: `load_o` is high in exactly one cycle of every 128. The sample inputs present at the next clock edge are the ones sent in the following frame.
- R13: A cycle with `soft_rst_i` high resets the coded level to 0 and restarts at channel A of frame 0, with `load_o` high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-cell clock, 128 times the sample rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst_i | input | 1 | Synchronous transmitter restart |
| left_i | input | 24 | Channel A sample, two's complement |
| right_i | input | 24 | Channel B sample, two's complement |
| load_o | output | 1 | Samples are captured at the next edge |
| mute_i | input | 1 | Force audio field to zero |
| wlen_i | input | 2 | Word-length code |
| rate_i | input | 2 | Sample-rate code for channel status |
| category_i | input | 8 | Category byte for channel status |
| emph_i | input | 1 | Pre-emphasis flag for channel status |
| clk_acc_i | input | 2 | Clock-accuracy field for channel status |
| out_sel_i | input | 2 | Output pin source select |
| sdout2_i | input | 1 | Second serial data line |
| pin_o | output | 1 | Output pin |

## Verification
On every cycle, the assertions check the biphase rules that follow from slot position alone. These are the slot-start toggle, the quiet validity and user slots, the exact 128-cycle spacing of `load_o`, the restart state, and the selector's constant-low and pass-through modes. The exact preamble pattern, the inverted patterns, the audio bits after truncation or mute, the parity and the content of each status field depend on the data, so only the bench's reference model shows them. That model rebuilds every sub-frame from the requirements and compares each half-cell, across several configurations and several full 192-frame blocks.

// File: rtl/spdif_cs_tx_pkg.sv
package spdif_cs_tx_pkg;

    localparam int unsigned SLOT_COUNT   = 32;
    localparam int unsigned SUB_HC       = 2 * SLOT_COUNT;
    localparam int unsigned FRAME_HC     = 2 * SUB_HC;
    localparam int unsigned HC_W         = $clog2(FRAME_HC);
    localparam int unsigned BLOCK_FRAMES = 192;
    localparam int unsigned FR_W         = $clog2(BLOCK_FRAMES);
    localparam int unsigned PRE_SLOTS    = 4;
    localparam int unsigned CS_USED      = 40;

    localparam logic [4:0] SLOT_CS  = 5'd30;
    localparam logic [4:0] SLOT_PAR = 5'd31;

    typedef enum logic [1:0] {
        PRE_X = 2'd0,
        PRE_Y = 2'd1,
        PRE_Z = 2'd2
    } preamble_e;

    function automatic logic [7:0] preamble_bits(input preamble_e kind);
        case (kind)
            PRE_Y:   return 8'b1110_0100;
            PRE_Z:   return 8'b1110_1000;
            default: return 8'b1110_0010;
        endcase
    endfunction

    function automatic logic [3:0] rate_field(input logic [1:0] code);
        case (code)
            2'b00:   return 4'h0;
            2'b01:   return 4'h2;
            2'b10:   return 4'h3;
            default: return 4'h1;
        endcase
    endfunction

    function automatic logic [3:0] wlen_field(input logic [1:0] code);
        case (code)
            2'b00:   return 4'h2;
            2'b01:   return 4'hA;
            default: return 4'hB;
        endcase
    endfunction

    function automatic int wlen_bits(input logic [1:0] code);
        case (code)
            2'b00:   return 16;
            2'b01:   return 20;
            default: return 24;
        endcase
    endfunction

endpackage

// File: rtl/spdif_cs_tx_timing.sv
module spdif_cs_tx_timing
    import spdif_cs_tx_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            soft_rst,
    output logic [HC_W-1:0] hc,
    output logic [FR_W-1:0] frame,
    output logic            load
);

    typedef struct packed {
        logic [HC_W-1:0] hc;
        logic [FR_W-1:0] frame;
    } tim_t;

    tim_t tim_d, tim_q;

    always_comb begin
        tim_d = tim_q;
        if (soft_rst) begin
            tim_d = '0;
        end else begin
            tim_d.hc = tim_q.hc + 1'b1;
            if (tim_q.hc == HC_W'(FRAME_HC - 1)) begin
                if (tim_q.frame == FR_W'(BLOCK_FRAMES - 1)) begin
                    tim_d.frame = '0;
                end else begin
                    tim_d.frame = tim_q.frame + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tim_q <= '0;
        end else begin
            tim_q <= tim_d;
        end
    end

    assign hc    = tim_q.hc;
    assign frame = tim_q.frame;
    assign load  = (tim_q.hc == '0);

endmodule

// File: rtl/spdif_cs_tx_status.sv
module spdif_cs_tx_status
    import spdif_cs_tx_pkg::*;
(
    input  logic [FR_W-1:0] frame,
    input  logic            chan_b,
    input  logic [7:0]      category,
    input  logic            emph,
    input  logic [1:0]      clk_acc,
    input  logic [1:0]      rate_code,
    input  logic [1:0]      wlen_code,
    output logic            cs_bit
);

    logic [CS_USED-1:0] field_vec;
    logic [CS_USED-1:0] shifted;

    always_comb begin
        field_vec        = '0;
        field_vec[3]     = emph;
        field_vec[15:8]  = category;
        field_vec[19:16] = 4'h0;
        field_vec[23:20] = chan_b ? 4'h2 : 4'h1;
        field_vec[27:24] = rate_field(rate_code);
        field_vec[29:28] = clk_acc;
        field_vec[35:32] = wlen_field(wlen_code);
        shifted          = field_vec >> frame;
        cs_bit           = (int'(frame) < CS_USED) && shifted[0];
    end

endmodule

// File: rtl/spdif_cs_tx_encoder.sv
module spdif_cs_tx_encoder
    import spdif_cs_tx_pkg::*;
#(
    parameter int unsigned AUDIO_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               soft_rst,
    input  logic [HC_W-1:0]    hc,
    input  logic               frame_zero,
    input  logic [AUDIO_W-1:0] word,
    input  logic               cs_bit,
    output logic               level
);

    localparam int DATA_END = int'(PRE_SLOTS + AUDIO_W);

    typedef struct packed {
        logic level;
        logic ref_lvl;
    } enc_t;

    enc_t enc_d, enc_q;

    logic [4:0]         slot;
    logic [AUDIO_W-1:0] shw;
    logic               dbit;
    logic               ref_now;
    preamble_e          kind;
    logic [7:0]         pat;

    always_comb begin
        enc_d   = enc_q;
        slot    = hc[5:1];
        shw     = word >> (slot - 5'd4);
        dbit    = 1'b0;
        if (int'(slot) < DATA_END) begin
            dbit = shw[0];
        end else if (slot == SLOT_CS) begin
            dbit = cs_bit;
        end else if (slot == SLOT_PAR) begin
            dbit = (^word) ^ cs_bit;
        end
        kind    = hc[6] ? PRE_Y : (frame_zero ? PRE_Z : PRE_X);
        pat     = preamble_bits(kind);
        ref_now = enc_q.ref_lvl;
        if (soft_rst) begin
            enc_d = '0;
        end else if (hc[5:3] == 3'd0) begin
            if (hc[2:0] == 3'd0) begin
                ref_now = enc_q.level;
            end
            enc_d.ref_lvl = ref_now;
            enc_d.level   = pat[3'd7 - hc[2:0]] ^ ref_now;
        end else if (!hc[0]) begin
            enc_d.level = ~enc_q.level;
        end else begin
            enc_d.level = enc_q.level ^ dbit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enc_q <= '0;
        end else begin
            enc_q <= enc_d;
        end
    end

    assign level = enc_q.level;

endmodule

// File: rtl/spdif_cs_tx.sv
module spdif_cs_tx
    import spdif_cs_tx_pkg::*;
#(
    parameter int unsigned AUDIO_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               soft_rst_i,
    input  logic [AUDIO_W-1:0] left_i,
    input  logic [AUDIO_W-1:0] right_i,
    output logic               load_o,
    input  logic               mute_i,
    input  logic [1:0]         wlen_i,
    input  logic [1:0]         rate_i,
    input  logic [7:0]         category_i,
    input  logic               emph_i,
    input  logic [1:0]         clk_acc_i,
    input  logic [1:0]         out_sel_i,
    input  logic               sdout2_i,
    output logic               pin_o
);

    typedef struct packed {
        logic [AUDIO_W-1:0] left;
        logic [AUDIO_W-1:0] right;
    } smp_t;

    smp_t               smp_d, smp_q;
    logic [AUDIO_W-1:0] keep;
    logic [HC_W-1:0]    hc_w;
    logic [FR_W-1:0]    frame_w;
    logic               cs_w;
    logic               lvl_w;
    logic [AUDIO_W-1:0] word_w;

    spdif_cs_tx_timing u_timing (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst_i),
        .hc       (hc_w),
        .frame    (frame_w),
        .load     (load_o)
    );

    spdif_cs_tx_status u_status (
        .frame     (frame_w),
        .chan_b    (hc_w[6]),
        .category  (category_i),
        .emph      (emph_i),
        .clk_acc   (clk_acc_i),
        .rate_code (rate_i),
        .wlen_code (wlen_i),
        .cs_bit    (cs_w)
    );

    always_comb begin
        keep = '0;
        for (int i = 0; i < int'(AUDIO_W); i++) begin
            keep[i] = (i >= int'(AUDIO_W) - wlen_bits(wlen_i));
        end
        smp_d = smp_q;
        if (soft_rst_i) begin
            smp_d = '0;
        end else if (load_o) begin
            smp_d.left  = mute_i ? '0 : (left_i & keep);
            smp_d.right = mute_i ? '0 : (right_i & keep);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_q <= '0;
        end else begin
            smp_q <= smp_d;
        end
    end

    assign word_w = hc_w[6] ? smp_q.right : smp_q.left;

    spdif_cs_tx_encoder #(.AUDIO_W(AUDIO_W)) u_encoder (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst_i),
        .hc         (hc_w),
        .frame_zero (frame_w == '0),
        .word       (word_w),
        .cs_bit     (cs_w),
        .level      (lvl_w)
    );

    assign pin_o = out_sel_i[1] ? sdout2_i : (out_sel_i[0] & lvl_w);

endmodule

// File: rtl/spdif_cs_tx_chk.sv
module spdif_cs_tx_chk
    import spdif_cs_tx_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            soft_rst_i,
    input logic            load_o,
    input logic            pin_o,
    input logic            sdout2_i,
    input logic [1:0]      out_sel_i,
    input logic [HC_W-1:0] hc,
    input logic            lvl
);

    logic [HC_W-1:0] gap_q;
    logic            seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (soft_rst_i) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (load_o) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else begin
            gap_q  <= gap_q + 1'b1;
        end
    end

    // R12
    load_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst_i)
        (load_o && seen_q) |-> (gap_q == HC_W'(FRAME_HC - 1)));

    // R12
    load_due_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst_i)
        (seen_q && gap_q == HC_W'(FRAME_HC - 1)) |-> load_o);

    // R4
    slot_edge_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst_i)
        (hc[5:3] != 3'd0 && !hc[0]) |=> (lvl != $past(lvl)));

    // R3
    quiet_slots_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst_i)
        (hc[5:0] == 6'd57 || hc[5:0] == 6'd59) |=> $stable(lvl));

    // R13
    restart_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_i |=> (load_o && !lvl));

    // R11
    sel_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sel_i == 2'b00) |-> !pin_o);

    // R11
    sel_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_sel_i[1] |-> (pin_o == sdout2_i));

endmodule

bind spdif_cs_tx spdif_cs_tx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst_i (soft_rst_i),
    .load_o     (load_o),
    .pin_o      (pin_o),
    .sdout2_i   (sdout2_i),
    .out_sel_i  (out_sel_i),
    .hc         (hc_w),
    .lvl        (lvl_w)
);

// File: tb/spdif_cs_tx_bench.sv
module spdif_cs_tx_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic [23:0] left_s = '0;
    logic [23:0] right_s = '0;
    logic        mute = 1'b0;
    logic [1:0]  wlen = 2'b10;
    logic [1:0]  rate = 2'b01;
    logic [7:0]  cat = 8'hA5;
    logic        emph = 1'b1;
    logic [1:0]  acc = 2'b10;
    logic [1:0]  sel = 2'b01;
    logic        sdout2 = 1'b0;
    logic        load;
    logic        pin;

    always #10 clk = ~clk;

    spdif_cs_tx u_spdif_cs_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst_i (soft_rst),
        .left_i     (left_s),
        .right_i    (right_s),
        .load_o     (load),
        .mute_i     (mute),
        .wlen_i     (wlen),
        .rate_i     (rate),
        .category_i (cat),
        .emph_i     (emph),
        .clk_acc_i  (acc),
        .out_sel_i  (sel),
        .sdout2_i   (sdout2),
        .pin_o      (pin)
    );

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    bit rand_sel = 1'b0;

    // inputs as seen by the design at the most recent rising edge
    bit          snapped = 1'b0;
    logic        s_rstn, s_soft, s_mute, s_emph;
    logic [23:0] s_l, s_r;
    logic [1:0]  s_wl, s_rate, s_acc;
    logic [7:0]  s_cat;

    // reference model state
    int          m_hc = 0;
    int          m_fr = 0;
    bit          m_lvl = 1'b0;
    bit          q[$];
    logic [23:0] m_l = '0;
    logic [23:0] m_r = '0;
    bit          m_mute = 1'b0;

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d (frame %0d halfcell %0d)",
                     tag, what, act, exp, m_fr, m_hc);
        end
    endtask

    function automatic bit cs_ref(input int idx, input int sub);
        bit [3:0] rf;
        bit [3:0] wf;
        rf = (s_rate == 2'd0) ? 4'h0 : (s_rate == 2'd1) ? 4'h2 : (s_rate == 2'd2) ? 4'h3 : 4'h1;
        wf = (s_wl == 2'd0) ? 4'h2 : (s_wl == 2'd1) ? 4'hA : 4'hB;
        if (idx == 3) return s_emph;
        if (idx >= 8 && idx <= 15) return s_cat[idx-8];
        if (idx == 20) return (sub == 0);
        if (idx == 21) return (sub == 1);
        if (idx >= 24 && idx <= 27) return rf[idx-24];
        if (idx == 28 || idx == 29) return s_acc[idx-28];
        if (idx >= 32 && idx <= 35) return wf[idx-32];
        return 1'b0;
    endfunction

    task automatic build_sub(input int sub);
        bit [7:0]    pat;
        bit          lv;
        bit          b;
        bit          rf0;
        logic [23:0] w;
        int          ones;
        ones = 0;
        pat = (sub == 1) ? 8'b11100100 : (m_fr == 0) ? 8'b11101000 : 8'b11100010;
        rf0 = m_lvl;
        w = (sub == 1) ? m_r : m_l;
        for (int i = 0; i < 8; i++) q.push_back(pat[7-i] ^ rf0);
        lv = rf0;
        for (int s = 4; s < 32; s++) begin
            if (s < 28) b = w[s-4];
            else if (s == 30) b = cs_ref(m_fr, sub);
            else if (s == 31) b = ones[0];
            else b = 1'b0;
            ones += int'(b);
            lv = ~lv;
            q.push_back(lv);
            if (b) lv = ~lv;
            q.push_back(lv);
        end
    endtask

    always @(posedge clk) begin
        s_rstn = rst_n; s_soft = soft_rst; s_mute = mute; s_emph = emph;
        s_l = left_s; s_r = right_s; s_wl = wlen; s_rate = rate; s_acc = acc; s_cat = cat;
        snapped = 1'b1;
    end

    always @(posedge clk) begin
        #2;
        left_s  <= 24'($urandom);
        right_s <= 24'($urandom);
        if (rand_sel) begin
            sel    <= 2'($urandom);
            sdout2 <= 1'($urandom);
        end
    end

    always @(negedge clk) begin
        bit    e;
        bit    exp_pin;
        string tag;
        int    slot;
        int    half;
        int    n;
        if (snapped && !done) begin
            if (!s_rstn || s_soft) begin
                tag = !s_rstn ? "R1" : "R13";
                m_hc = 0; m_fr = 0; m_lvl = 1'b0; q.delete();
                e = 1'b0;
            end else begin
                slot = (m_hc % 64) / 2;
                half = m_hc % 2;
                if (m_hc == 0) begin
                    n = (s_wl == 2'd0) ? 16 : (s_wl == 2'd1) ? 20 : 24;
                    m_mute = s_mute;
                    m_l = s_mute ? 24'd0 : ((s_l >> (24 - n)) << (24 - n));
                    m_r = s_mute ? 24'd0 : ((s_r >> (24 - n)) << (24 - n));
                end
                if (m_hc % 64 == 0) build_sub(m_hc / 64);
                e = q.pop_front();
                m_lvl = e;
                if (slot < 4) tag = "R2";
                else if (half == 0) tag = "R4";
                else if (slot < 28) tag = m_mute ? "R6" : "R5";
                else if (slot < 30) tag = "R3";
                else if (slot == 31) tag = "R7";
                else if (m_fr >= 16 && m_fr <= 23) tag = "R8";
                else if (m_fr >= 24 && m_fr <= 27) tag = "R9";
                else tag = "R10";
                m_hc++;
                if (m_hc == 128) begin
                    m_hc = 0;
                    m_fr = (m_fr + 1) % 192;
                end
            end
            exp_pin = (sel == 2'b00) ? 1'b0 : (sel == 2'b01) ? e : sdout2;
            chk(pin === exp_pin, (sel == 2'b01) ? tag : "R11", "pin level", int'(pin), int'(exp_pin));
            chk(load === (m_hc == 0), "R12", "load strobe", int'(load), int'(m_hc == 0));
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic restart(input logic [1:0] wl, input logic [1:0] rt, input logic [7:0] ct,
                           input logic em, input logic [1:0] ac, input logic mt);
        #2;
        soft_rst = 1'b1; wlen = wl; rate = rt; cat = ct; emph = em; acc = ac; mute = mt;
        @(posedge clk);
        #2;
        soft_rst = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        // 24-bit words, 48 kHz, emphasis on, spans more than one block
        repeat (200 * 128) @(posedge clk);
        // 16-bit words, 32 kHz
        restart(2'b00, 2'b10, 8'h3C, 1'b0, 2'b01, 1'b0);
        repeat (200 * 128) @(posedge clk);
        // 20-bit words, rate not indicated, output selector exercised
        restart(2'b01, 2'b11, 8'h81, 1'b1, 2'b11, 1'b0);
        rand_sel = 1'b1;
        repeat (40 * 128) @(posedge clk);
        rand_sel = 1'b0;
        @(posedge clk);
        #3;
        sel = 2'b01;
        repeat (20 * 128) @(posedge clk);
        // muted, 44.1 kHz, restart in the middle of a sub-frame
        restart(2'b11, 2'b00, 8'h5A, 1'b0, 2'b00, 1'b1);
        repeat (37) @(posedge clk);
        restart(2'b11, 2'b00, 8'h5A, 1'b0, 2'b00, 1'b1);
        repeat (200 * 128) @(posedge clk);
        finish_run();
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            finish_run();
        end
    end

endmodule